// File: doc/BRIEF.md
# Floating-Point Exception Trap Arbiter

This block sits after a floating-point execution unit and decides whether the exception flags of a finished instruction raise an arithmetic trap. Each instruction presents a strobe, a five-bit IEEE flag vector, the index of its destination register and one mode bit. The mode bit selects one of two policies. Without software completion, any raised flag traps and the enable mask is not consulted. With software completion, the raw flags first go into a sticky status register, and only the flags that the control register does not suppress can trap.

When a trap fires, the block sends a one-cycle pulse with a seven-bit hardware summary code to the trap logic. It also sets the bit of the destination register in a cumulative 64-bit register-write mask. A dedicated clear strobe empties the sticky status and the register-write mask. Both values are brought out as read-only outputs. The arithmetic that produces the flags and the vectoring of the trap are outside this block.

Top module: `fp_trap_arbiter`

## Requirements
- R1: A strobe whose flag vector is all zero changes neither the sticky status nor the register-write mask, and it produces no trap.
- R2: With `exc_swc` low, any nonzero flag vector produces a trap whatever the suppress mask holds, and the sticky status is left unchanged.
- R3: Every trap sets bit `dest_reg` of `reg_mask`. Bits that were already set stay set. When no trap fires, the mask does not change.
- R4: The flag input uses bit 0 for invalid, bit 1 for divide-by-zero, bit 2 for overflow, bit 3 for underflow and bit 4 for inexact. The summary code maps these flags to code bits 1, 2, 3, 4 and 5 respectively. Code bit 0 (software completion) and code bit 6 (integer overflow) are always 0. Several code bits may be set together.
- R5: With `exc_swc` high, the raw flags are OR-ed into `sticky_status` whether or not a trap follows.
- R6: With `exc_swc` high, a flag whose `suppress_mask` bit is 1 is removed. A trap, together with its `reg_mask` update, happens only if some flag remains, and the summary code shows only the remaining flags.
- R7: `trap_pulse` and `trap_code` are registered. They are valid only in the cycle after the clock edge that samples the strobe. `trap_pulse` is 0 at all other times, and `trap_code` is 0 whenever no trap is being reported.
- R8: `clr` sets `sticky_status` and `reg_mask` to zero. When `clr` and an update arrive in the same cycle, the clear wins, but the trap pulse for that strobe is still produced.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exc_valid | input | 1 | Strobe: an instruction's flags are present |
| exc_flags | input | 5 | IEEE flags {inexact, underflow, overflow, divzero, invalid} |
| exc_swc | input | 1 | 1 selects the software-completion policy |
| dest_reg | input | 6 | Destination register index |
| suppress_mask | input | 5 | Control-register bits; 1 suppresses the trap for that flag |
| clr | input | 1 | Clears sticky status and register-write mask |
| trap_pulse | output | 1 | One-cycle arithmetic trap request |
| trap_code | output | 7 | Hardware exception summary |
| sticky_status | output | 5 | Accumulated software-completion flags |
| reg_mask | output | 64 | Cumulative mask of destination registers that trapped |

## Verification
The clear strobe and a flag update can arrive in the same cycle. The bench provokes this by asserting `clr` together with a software-completion strobe that carries unsuppressed flags. It then expects a trap pulse with the matching code one cycle later, while the sticky status and the register-write mask read zero. A second collision is a strobe whose flags are all suppressed while `clr` is high. In that case no trap may fire and both registers must still read zero.

// File: rtl/fptrap_pkg.sv
// Shared constants for the FP trap arbiter.
// Assumes the flag order {inexact, underflow, overflow, divzero, invalid}.
package fptrap_pkg;
    localparam int FLAG_W = 5;
    localparam int CODE_W = 7;

    // Flag bit positions on the input vector
    localparam int FLG_INV = 0;
    localparam int FLG_DZE = 1;
    localparam int FLG_FOV = 2;
    localparam int FLG_UNF = 3;
    localparam int FLG_INE = 4;

    // Summary code positions, LSB first: SWC, INV, DZE, FOV, UNF, INE, IOV
    localparam int CODE_SWC  = 0;
    localparam int CODE_BASE = 1;
    localparam int CODE_IOV  = 6;

    typedef logic [FLAG_W-1:0] flags_t;
    typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/fptrap_policy.sv
// Trap policy: picks the flags that trap under the selected mode.
// Assumes the inputs are qualified by exc_valid. The block is purely combinational.
module fptrap_policy
    import fptrap_pkg::*;
(
    input  logic   valid,
    input  flags_t flags,
    input  logic   swc,
    input  flags_t suppress,
    output logic   trap_req,
    output flags_t trap_flags,
    output flags_t sticky_set
);
    flags_t eff;

    // Select the flags that may trap: all of them without completion, unsuppressed ones with it
    always_comb begin
        eff        = swc ? (flags & ~suppress) : flags;
        trap_flags = valid ? eff : '0;
        trap_req   = |trap_flags;
        sticky_set = (valid && swc) ? flags : '0;
    end
endmodule

// File: rtl/fptrap_encode.sv
// Maps IEEE flags onto the hardware summary code.
// SWC and IOV are never raised by this block.
module fptrap_encode
    import fptrap_pkg::*;
(
    input  flags_t flags,
    output code_t  code
);
    // Place each flag at its own code bit
    for (genvar i = 0; i < FLAG_W; i++) begin : g_map
        assign code[CODE_BASE + i] = flags[i];
    end
    assign code[CODE_SWC] = 1'b0;
    assign code[CODE_IOV] = 1'b0;
endmodule

// File: rtl/fptrap_state.sv
// Sticky status and cumulative register-write mask.
// Assumes clear has priority over any same-cycle update. Reset is synchronous and active low.
module fptrap_state
    import fptrap_pkg::*;
#(
    parameter int NREG  = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  flags_t          sticky_set,
    input  logic            mark,
    input  logic [IDX_W-1:0] idx,
    output flags_t          sticky,
    output logic [NREG-1:0] regmask
);
    logic [NREG-1:0] onehot;

    // Decode the destination index into a single mask bit
    always_comb begin
        onehot = '0;
        onehot[idx] = mark;
    end

    // Accumulate the sticky flags; clear wins
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sticky <= '0;
        else               sticky <= sticky | sticky_set;
    end

    // Accumulate the registers that trapped; clear wins
    always_ff @(posedge clk) begin
        if (!rst_n || clr) regmask <= '0;
        else               regmask <= regmask | onehot;
    end
endmodule

// File: rtl/fp_trap_arbiter.sv
// FP exception trap arbiter top.
// Decides on each strobe whether its flags trap, and registers a one-cycle
// pulse with its summary code. Assumes at most one strobe per cycle.
module fp_trap_arbiter
    import fptrap_pkg::*;
#(
    parameter int NREG  = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_valid,
    input  logic [4:0]       exc_flags,
    input  logic             exc_swc,
    input  logic [IDX_W-1:0] dest_reg,
    input  logic [4:0]       suppress_mask,
    input  logic             clr,
    output logic             trap_pulse,
    output logic [6:0]       trap_code,
    output logic [4:0]       sticky_status,
    output logic [NREG-1:0]  reg_mask
);
    logic   trap_req;
    flags_t trap_flags;
    flags_t sticky_set;
    code_t  code_next;

    fptrap_policy u_policy (
        .valid      (exc_valid),
        .flags      (exc_flags),
        .swc        (exc_swc),
        .suppress   (suppress_mask),
        .trap_req   (trap_req),
        .trap_flags (trap_flags),
        .sticky_set (sticky_set)
    );

    fptrap_encode u_encode (
        .flags (trap_flags),
        .code  (code_next)
    );

    fptrap_state #(.NREG(NREG)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .sticky_set (sticky_set),
        .mark       (trap_req),
        .idx        (dest_reg),
        .sticky     (sticky_status),
        .regmask    (reg_mask)
    );

    // Register the trap pulse and its code for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pulse <= 1'b0;
            trap_code  <= '0;
        end else begin
            trap_pulse <= trap_req;
            trap_code  <= trap_req ? code_next : '0;
        end
    end
endmodule

// File: rtl/fptrap_checker.sv
// Property checker for fp_trap_arbiter, attached by bind.
// Observes ports only.
module fptrap_checker #(
    parameter int NREG  = 64,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_valid,
    input logic [4:0]       exc_flags,
    input logic             exc_swc,
    input logic [IDX_W-1:0] dest_reg,
    input logic [4:0]       suppress_mask,
    input logic             clr,
    input logic             trap_pulse,
    input logic [6:0]       trap_code,
    input logic [4:0]       sticky_status,
    input logic [NREG-1:0]  reg_mask
);
    AST_ZERO_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid || exc_flags == 5'd0) |=> (!trap_pulse && trap_code == 7'd0)); // R1
    AST_ZERO_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (!exc_valid || exc_flags == 5'd0)) |=> ($stable(sticky_status) && $stable(reg_mask))); // R1
    AST_RAW_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !exc_swc && exc_flags != 5'd0) |=> (trap_pulse && trap_code[5:1] == $past(exc_flags))); // R2
    AST_RAW_NO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !exc_swc && !clr) |=> $stable(sticky_status)); // R2
    AST_MARK_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !exc_swc && exc_flags != 5'd0 && !clr) |=> reg_mask[$past(dest_reg)]); // R3
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((reg_mask & $past(reg_mask)) == $past(reg_mask))); // R3
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_code[0] && !trap_code[6])); // R4
    AST_SWC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_swc && !clr) |=> (sticky_status == ($past(sticky_status) | $past(exc_flags)))); // R5
    AST_SWC_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_swc) |=> (trap_code[5:1] == $past(exc_flags & ~suppress_mask))); // R6
    AST_CODE_ONLY_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_pulse |-> (trap_code == 7'd0)); // R7
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sticky_status == 5'd0 && reg_mask == '0)); // R8
endmodule

bind fp_trap_arbiter fptrap_checker #(.NREG(NREG)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_valid     (exc_valid),
    .exc_flags     (exc_flags),
    .exc_swc       (exc_swc),
    .dest_reg      (dest_reg),
    .suppress_mask (suppress_mask),
    .clr           (clr),
    .trap_pulse    (trap_pulse),
    .trap_code     (trap_code),
    .sticky_status (sticky_status),
    .reg_mask      (reg_mask)
);

// File: tb/fp_trap_arbiter_tb.sv
// Directed bench for fp_trap_arbiter: one task per scenario.
module fp_trap_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_flags = '0;
    logic        exc_swc = 1'b0;
    logic [5:0]  dest_reg = '0;
    logic [4:0]  suppress_mask = '0;
    logic        clr = 1'b0;
    logic        trap_pulse;
    logic [6:0]  trap_code;
    logic [4:0]  sticky_status;
    logic [63:0] reg_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [4:0]  exp_sticky = '0;
    logic [63:0] exp_mask   = '0;

    always #4 clk = ~clk;

    fp_trap_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_flags(exc_flags),
        .exc_swc(exc_swc), .dest_reg(dest_reg), .suppress_mask(suppress_mask),
        .clr(clr), .trap_pulse(trap_pulse), .trap_code(trap_code),
        .sticky_status(sticky_status), .reg_mask(reg_mask)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one strobe at a falling edge, then read the outputs at the next falling edge
    task automatic strobe(input logic [4:0] fl, input logic swc, input logic [5:0] dst,
                          input logic [4:0] sup, input logic c,
                          output logic tp, output logic [6:0] tc);
        @(negedge clk);
        exc_valid = 1'b1; exc_flags = fl; exc_swc = swc; dest_reg = dst;
        suppress_mask = sup; clr = c;
        @(negedge clk);
        tp = trap_pulse; tc = trap_code;
        exc_valid = 1'b0; exc_flags = '0; clr = 1'b0;
    endtask

    // Bench-side model of the expected result, taken from the requirements
    task automatic expect_step(input logic [4:0] fl, input logic swc, input logic [5:0] dst,
                               input logic [4:0] sup, input logic c,
                               output logic etp, output logic [6:0] etc);
        logic [4:0] eff;
        eff = swc ? (fl & ~sup) : fl;
        etp = (eff != 5'd0);
        etc = etp ? {1'b0, eff, 1'b0} : 7'd0;
        if (swc) exp_sticky = exp_sticky | fl;
        if (etp) exp_mask = exp_mask | (64'd1 << dst);
        if (c) begin exp_sticky = '0; exp_mask = '0; end
    endtask

    task automatic run(input string req, input logic [4:0] fl, input logic swc,
                       input logic [5:0] dst, input logic [4:0] sup, input logic c);
        logic tp, etp;
        logic [6:0] tc, etc;
        expect_step(fl, swc, dst, sup, c, etp, etc);
        strobe(fl, swc, dst, sup, c, tp, tc);
        check(req, "trap_pulse", {63'd0, tp}, {63'd0, etp});
        check(req, "trap_code", {57'd0, tc}, {57'd0, etc});
        check(req, "sticky_status", {59'd0, sticky_status}, {59'd0, exp_sticky});
        check(req, "reg_mask", reg_mask, exp_mask);
    endtask

    task automatic t_reset;
        check("R9", "trap_pulse", {63'd0, trap_pulse}, 64'd0);
        check("R9", "trap_code", {57'd0, trap_code}, 64'd0);
        check("R9", "sticky_status", {59'd0, sticky_status}, 64'd0);
        check("R9", "reg_mask", reg_mask, 64'd0);
    endtask

    task automatic t_zero_flags;
        run("R1", 5'd0, 1'b0, 6'd9, 5'd0, 1'b0);
        run("R1", 5'd0, 1'b1, 6'd9, 5'd0, 1'b0);
    endtask

    task automatic t_raw_mode;
        // R2: every flag is suppressed, yet the raw policy still traps
        run("R2", 5'b10101, 1'b0, 6'd3, 5'b11111, 1'b0);
        @(negedge clk);
        check("R7", "pulse drops after one cycle", {63'd0, trap_pulse}, 64'd0);
        check("R7", "code drops after one cycle", {57'd0, trap_code}, 64'd0);
    endtask

    task automatic t_each_flag;
        for (int i = 0; i < 5; i++) begin
            // R4: each flag lands on its own code bit
            run("R4", 5'd1 << i, 1'b0, (i == 0) ? 6'd0 : 6'd63, 5'd0, 1'b0);
        end
    endtask

    task automatic t_swc_all_suppressed;
        // R5 and R6: the flags stick, but nothing traps and reg_mask stays put
        run("R5", 5'b01100, 1'b1, 6'd20, 5'b11111, 1'b0);
    endtask

    task automatic t_swc_partial;
        // R6: only overflow is left unsuppressed
        run("R6", 5'b00111, 1'b1, 6'd40, 5'b00011, 1'b0);
    endtask

    task automatic t_back_to_back;
        // R7 and R3: two strobes in consecutive cycles give two pulses and mark both registers
        logic [6:0] tc;
        @(negedge clk);
        exc_valid = 1'b1; exc_swc = 1'b0; exc_flags = 5'b00001; dest_reg = 6'd11;
        @(negedge clk);
        tc = trap_code;
        check("R7", "first pulse", {63'd0, trap_pulse}, 64'd1);
        check("R7", "first code", {57'd0, tc}, 64'h02);
        exc_flags = 5'b10000; dest_reg = 6'd12;
        @(negedge clk);
        exc_valid = 1'b0; exc_flags = '0;
        exp_mask = exp_mask | (64'd1 << 11) | (64'd1 << 12);
        check("R7", "second pulse", {63'd0, trap_pulse}, 64'd1);
        check("R7", "second code", {57'd0, trap_code}, 64'h20);
        check("R3", "both registers marked", reg_mask, exp_mask);
    endtask

    task automatic t_clear_collide;
        // R8: a clear and an unsuppressed update arrive in the same cycle
        run("R8", 5'b11000, 1'b1, 6'd5, 5'b00000, 1'b1);
        // R8: rebuild some state, then clear it together with a fully suppressed strobe
        run("R8", 5'b00010, 1'b0, 6'd7, 5'b00000, 1'b0);
        run("R8", 5'b00110, 1'b1, 6'd8, 5'b11111, 1'b1);
    endtask

    task automatic t_clear_alone;
        run("R8", 5'b00001, 1'b1, 6'd33, 5'b00000, 1'b0);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        exp_sticky = '0; exp_mask = '0;
        check("R8", "sticky after clear", {59'd0, sticky_status}, 64'd0);
        check("R8", "reg_mask after clear", reg_mask, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_flags();
        t_raw_mode();
        t_each_flag();
        t_swc_all_suppressed();
        t_swc_partial();
        t_back_to_back();
        t_clear_collide();
        t_clear_alone();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule